// File: doc/BRIEF.md
# Fractional Clock-Enable Generator

This block is the rate datapath of a clock root. Each cycle on which `src_tick` is high counts as one edge of the selected source. A half-step pre-divider divides this tick stream by (hid+1)/2. An optional M/N ratio counter follows it and keeps m of every n pre-divided pulses. The result leaves the block as a train of one-cycle enable pulses on `clk_en_out`. Source selection, the phase-locked loops and any register bank sit outside the block.

Configuration arrives as raw field values together with a one-cycle `cfg_commit` strobe. The N field uses a complemented encoding: it holds the bitwise inverse of (n − m). The block rebuilds n from that field and m. A committed configuration is held as pending. It becomes active only on a cycle that emits an output pulse, so a rate change never cuts a pulse interval short. When the new configuration is applied, both accumulators restart from zero.

Top module: `frac_clk_gen`

## Requirements
- R1: After synchronous reset, `clk_en_out` is low and the active configuration is full bypass (hid = 0, counter off).
- R2: With hid = 0 and the counter off, every `src_tick` produces exactly one output pulse.
- R3: With hid ≥ 1, K source ticks counted from an apply produce floor(2K/(hid+1)) pre-divided pulses. hid = 1 therefore divides by one.
- R4: With a nonzero mode field, n = (~cfg_n_word) + m over MN_W bits with one extra carry bit. P pre-divided pulses counted from an apply then yield floor(P·m/n) output pulses.
- R5: With mode field 0, or with a decoded n of 0, the ratio counter is bypassed and the M and N fields have no effect.
- R6: Every nonzero mode value (1, 2 or 3) engages the counter in the same way. Value 2 is the customary fractional setting.
- R7: A commit takes effect only on the next cycle that emits an output pulse. Configuration inputs without a commit are ignored.
- R8: An output pulse is one cycle wide and appears exactly one cycle after the source tick that caused it. It never appears without a tick.
- R9: The pre-divider accumulator stays below hid+1, and the ratio accumulator stays below n, while each stage is engaged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| src_tick | input | 1 | One source edge per high cycle |
| cfg_hid | input | HID_W | Half-step divider field (0 = bypass) |
| cfg_mode | input | 2 | Counter mode field (0 = counter off) |
| cfg_m_word | input | MN_W | Ratio numerator m |
| cfg_n_word | input | MN_W | Inverse of (n − m) |
| cfg_commit | input | 1 | Latch the configuration fields as pending |
| clk_en_out | output | 1 | Output enable pulse train |

## Verification
Several properties are checked on every cycle. An output pulse always follows a tick by one cycle. Full bypass passes ticks straight through. The active configuration changes only on a pulse cycle. Both accumulators stay within their wrap bounds. The pulse counts over a window can only be shown by the bench scenarios: floor(2K/(hid+1)), the m/n thinning, the decoding of the complemented N field, and the delay before a mid-run commit takes effect. For these, the bench drives a known number of ticks after an apply and compares the counted pulses with values it computes from the requirements.

// File: rtl/fcg_pkg.sv
package fcg_pkg;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'd0,
        MODE_ALT1 = 2'd1,
        MODE_DUAL = 2'd2,
        MODE_ALT3 = 2'd3
    } mnd_mode_e;

    // Counter is engaged for any nonzero mode, unless n decodes to zero.
    function automatic logic counter_engaged(mnd_mode_e mode, logic n_is_zero);
        return (mode != MODE_OFF) && !n_is_zero;
    endfunction

endpackage

// File: rtl/halfstep_prediv.sv
module halfstep_prediv #(
    parameter int HID_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             tick,
    input  logic [HID_W-1:0] hid,
    output logic             fire
);
    localparam int AW = HID_W + 2;

    logic [AW-1:0] acc_q;
    logic [AW-1:0] sum;
    logic [AW-1:0] lim;
    logic          bypass;

    // Each source edge contributes two half-steps; a pulse is due every hid+1.
    always_comb begin
        bypass = (hid == '0);
        sum    = acc_q + AW'(2);
        lim    = AW'(hid) + AW'(1);
        fire   = tick && (bypass || (sum >= lim));
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            acc_q <= '0;
        end else if (tick && !bypass) begin
            acc_q <= fire ? (sum - lim) : sum;
        end
    end

    a_r9_prediv_bound: assert property (@(posedge clk) disable iff (rst)
        (hid != '0) |-> (acc_q < lim))
        else $error("R9: pre-divider accumulator out of range");

endmodule

// File: rtl/mn_ratio_counter.sv
module mn_ratio_counter #(
    parameter int MN_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clear,
    input  logic            pulse_in,
    input  logic            engaged,
    input  logic [MN_W-1:0] m_val,
    input  logic [MN_W:0]   n_val,
    output logic            fire
);
    localparam int AW = MN_W + 2;

    logic [AW-1:0] acc_q;
    logic [AW-1:0] sum;
    logic [AW-1:0] wrap;

    always_comb begin
        sum  = acc_q + AW'(m_val);
        wrap = AW'(n_val);
        fire = pulse_in && (!engaged || (sum >= wrap));
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            acc_q <= '0;
        end else if (pulse_in && engaged) begin
            acc_q <= fire ? (sum - wrap) : sum;
        end
    end

    a_r9_ratio_bound: assert property (@(posedge clk) disable iff (rst)
        engaged |-> (acc_q < wrap))
        else $error("R9: ratio accumulator out of range");

endmodule

// File: rtl/frac_clk_gen.sv
module frac_clk_gen
    import fcg_pkg::*;
#(
    parameter int HID_W = 5,
    parameter int MN_W  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             src_tick,
    input  logic [HID_W-1:0] cfg_hid,
    input  logic [1:0]       cfg_mode,
    input  logic [MN_W-1:0]  cfg_m_word,
    input  logic [MN_W-1:0]  cfg_n_word,
    input  logic             cfg_commit,
    output logic             clk_en_out
);
    localparam int NW = MN_W + 1;

    typedef struct packed {
        logic [HID_W-1:0] hid;
        logic             mn_on;
        logic [MN_W-1:0]  m;
        logic [NW-1:0]    n;
    } rate_cfg_t;

    rate_cfg_t act_q, pnd_q, decoded;
    logic      pend_q;
    logic      pre_fire, out_fire, apply;

    // Rebuild n from its complemented field: n = inverse(N) + m.
    always_comb begin
        decoded.hid   = cfg_hid;
        decoded.m     = cfg_m_word;
        decoded.n     = {1'b0, ~cfg_n_word} + {1'b0, cfg_m_word};
        decoded.mn_on = counter_engaged(mnd_mode_e'(cfg_mode), decoded.n == '0);
    end

    assign apply = out_fire && pend_q;

    halfstep_prediv #(.HID_W(HID_W)) u_prediv (
        .clk   (clk),
        .rst   (rst),
        .clear (apply),
        .tick  (src_tick),
        .hid   (act_q.hid),
        .fire  (pre_fire)
    );

    mn_ratio_counter #(.MN_W(MN_W)) u_ratio (
        .clk      (clk),
        .rst      (rst),
        .clear    (apply),
        .pulse_in (pre_fire),
        .engaged  (act_q.mn_on),
        .m_val    (act_q.m),
        .n_val    (act_q.n),
        .fire     (out_fire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q      <= '0;
            pnd_q      <= '0;
            pend_q     <= 1'b0;
            clk_en_out <= 1'b0;
        end else begin
            clk_en_out <= out_fire;
            if (apply) begin
                act_q <= pnd_q;
            end
            if (cfg_commit) begin
                pnd_q  <= decoded;
                pend_q <= 1'b1;
            end else if (apply) begin
                pend_q <= 1'b0;
            end
        end
    end

    a_r8_pulse_needs_tick: assert property (@(posedge clk) disable iff (rst)
        clk_en_out |-> $past(src_tick))
        else $error("R8: output pulse without a source tick");

    a_r7_switch_on_pulse: assert property (@(posedge clk) disable iff (rst)
        !$stable(act_q) |-> clk_en_out)
        else $error("R7: configuration changed outside a pulse cycle");

    a_r2_bypass_passthrough: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && ($past(act_q.hid) == '0) && !$past(act_q.mn_on))
            |-> (clk_en_out == $past(src_tick)))
        else $error("R2: bypass does not pass ticks through");

    a_r1_reset_state: assert property (@(posedge clk)
        $past(rst) |-> (!clk_en_out && (act_q == '0)))
        else $error("R1: reset state wrong");

endmodule

// File: tb/frac_clk_gen_bench.sv
module frac_clk_gen_bench;
    localparam int HID_W = 5;
    localparam int MN_W  = 8;
    localparam int MASK  = (1 << MN_W) - 1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             src_tick = 1'b0;
    logic [HID_W-1:0] cfg_hid = '0;
    logic [1:0]       cfg_mode = '0;
    logic [MN_W-1:0]  cfg_m_word = '0;
    logic [MN_W-1:0]  cfg_n_word = '0;
    logic             cfg_commit = 1'b0;
    logic             clk_en_out;

    int checks = 0;
    int errors = 0;
    int exp_q[$];
    int win_cnt = 0;
    bit win = 1'b0;

    frac_clk_gen #(.HID_W(HID_W), .MN_W(MN_W)) u_frac_clk_gen (
        .clk(clk), .rst(rst), .src_tick(src_tick), .cfg_hid(cfg_hid),
        .cfg_mode(cfg_mode), .cfg_m_word(cfg_m_word), .cfg_n_word(cfg_n_word),
        .cfg_commit(cfg_commit), .clk_en_out(clk_en_out)
    );

    always #10 clk = ~clk;

    // Monitor: counts output pulses inside a window, sampled 2 ns after each edge.
    always @(posedge clk) begin
        #2;
        if (win && clk_en_out) win_cnt++;
    end

    task automatic check(string req, int actual, int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    function automatic int n_field(int n, int m);
        return (~(n - m)) & MASK;
    endfunction

    // Expected pulses from the requirements: R3 pre-division, R4/R5/R6 ratio.
    function automatic int model(int hid, int mode, int m, int nword, int k);
        int p, n;
        p = (hid == 0) ? k : (2 * k) / (hid + 1);
        n = ((~nword) & MASK) + m;
        if (mode != 0 && n != 0) return (p * m) / n;
        return p;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; src_tick = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // Driver: commit, tick until the pulse that applies it, then run K ticks.
    task automatic run_window(string req, int hid, int mode, int m, int nword,
                              int k, bit junk, int exp_wait, output int waited);
        exp_q.push_back(model(hid, mode, m, nword, k));
        @(negedge clk);
        cfg_hid = HID_W'(hid); cfg_mode = 2'(mode);
        cfg_m_word = MN_W'(m); cfg_n_word = MN_W'(nword);
        cfg_commit = 1'b1; src_tick = 1'b0;
        @(negedge clk);
        cfg_commit = 1'b0;
        if (junk) begin
            cfg_hid = 5'd1; cfg_mode = 2'd2; cfg_m_word = 8'd1; cfg_n_word = 8'hFE;
        end
        src_tick = 1'b1;
        waited = 0;
        do begin
            @(negedge clk);
            waited++;
        end while (!clk_en_out && waited < 100);
        if (exp_wait > 0) check({req, " ticks to apply"}, waited, exp_wait);
        win_cnt = 0; win = 1'b1;
        repeat (k) @(negedge clk);
        src_tick = 1'b0;
        repeat (2) @(negedge clk);
        win = 1'b0;
        check(req, win_cnt, exp_q.pop_front());
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int w;
        do_reset();
        @(negedge clk);
        check("R1 out low after reset", int'(clk_en_out), 0);

        // R8: single tick, pulse exactly one cycle later and one cycle wide
        src_tick = 1'b1;
        @(negedge clk);
        src_tick = 1'b0;
        check("R8 pulse after tick", int'(clk_en_out), 1);
        @(negedge clk);
        check("R8 pulse width", int'(clk_en_out), 0);

        do_reset();
        run_window("R2 bypass", 0, 0, 0, 0, 10, 1'b0, 1, w);
        do_reset();
        run_window("R3 hid=1", 1, 0, 0, 0, 12, 1'b0, 1, w);
        do_reset();
        run_window("R3,R9 hid=2", 2, 0, 0, 0, 12, 1'b0, 1, w);
        do_reset();
        run_window("R3 hid=4", 4, 0, 0, 0, 10, 1'b0, 1, w);
        do_reset();
        run_window("R4 m=1 n=3", 0, 2, 1, n_field(3, 1), 12, 1'b0, 1, w);
        do_reset();
        run_window("R4,R9 hid=2 m=3 n=4", 2, 2, 3, n_field(4, 3), 16, 1'b0, 1, w);
        do_reset();
        run_window("R4 m=n=5", 0, 2, 5, n_field(5, 5), 7, 1'b0, 1, w);
        do_reset();
        run_window("R5 mode off ignores M/N", 0, 0, 1, n_field(7, 1), 9, 1'b0, 1, w);
        do_reset();
        run_window("R6 mode=1 m=1 n=2", 0, 1, 1, n_field(2, 1), 10, 1'b0, 1, w);
        do_reset();
        run_window("R6 mode=3 m=2 n=5", 3, 3, 2, n_field(5, 2), 15, 1'b0, 1, w);
        do_reset();
        // R7: inputs changed after the commit but never committed are ignored
        run_window("R7 uncommitted change", 5, 0, 0, 0, 12, 1'b1, 1, w);
        // R7: mid-run commit waits for the old config's next pulse (3 ticks at hid=5)
        run_window("R7 mid-run commit", 0, 0, 0, 0, 6, 1'b0, 3, w);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule